// File: doc/BRIEF.md
# Remote Reconfiguration Supervisor

This block decides which configuration image a reconfigurable device should boot and when it must give up on an application image. After reset it sits in factory mode. Software running from the factory image writes a 39-bit control word holding a boot address field, a watchdog field and several option bits. A write that also carries the launch command moves the block into application mode. The boot address output then points at the configured image.

While the application runs, the block watches a set of error pulses: a CRC error, an externally signalled error, a done signal that arrived too early, and an invalid image. It also runs a user watchdog that the application must kick. Any of these events issues a single-cycle reconfiguration request and returns the block to factory mode, which forces the boot address to zero. Each cause is latched into a sticky status register, and reading that register clears it.

The register port has no back-pressure. A read request is always accepted. Its data appears one cycle later, qualified by `rd_valid` for exactly one cycle, and the consumer must take it then. The write port is plain: a write is taken in the cycle `wr_en` is high.

Top module: `recfg_supervisor`

## Requirements
- R1: After reset the block is in factory mode, `boot_addr` is 0, and a control read returns the default word 39'h78_0000_0000. In that word bits 38, 37, 36 and 35 are 1 and all other bits are 0.
- R2: The control word layout is: bits 11:0 watchdog field, bits 33:12 address field, bit 34 spare (default 0), bit 35 watchdog enable, bit 36 oscillator select, bit 37 early-done/invalid-image check enable, bit 38 spare (default 1). In factory mode, a write without launch stores the word, and a later read returns it.
- R3: A read with `rd_sel`=0 returns the control word and one with `rd_sel`=1 returns the status bits, zero-extended. Data is valid one cycle after `rd_en`, with `rd_valid` high.
- R4: A write with `wr_launch`=1 in factory mode stores the word and enters application mode. From the next cycle, `boot_addr` equals the address field followed by two zero bits.
- R5: In application mode, every control write is ignored, including writes to the option bits. The stored word is unchanged.
- R6: When application mode is entered with bit 35 set, the watchdog loads the 29-bit count {field, 17'd8} and decrements it each cycle. A `wd_kick` reloads it. If it sits at zero for a cycle without a kick, a watchdog trigger fires. With field 0, the request appears 9 clock edges after the last load. With bit 35 clear, no watchdog trigger occurs.
- R7: `err_early_done` and `err_bad_image` trigger a fallback only when bit 37 of the stored word is set. Otherwise they are ignored.
- R8: `err_crc` and `err_ext` trigger a fallback in application mode regardless of option bits.
- R9: On any trigger, `reconfig_req` is high for exactly one cycle after the triggering edge. In that same cycle `app_mode` is low and `boot_addr` is 0.
- R10: The status bits are: bit 0 CRC error, bit 1 external error, bit 2 early done, bit 3 invalid image, bit 4 watchdog. They stay set until a status read, which returns them and clears them. A trigger in the same cycle as the read is kept for the next read.
- R11: Triggers arriving together are all recorded, and only one single-cycle request is issued.
- R12: In factory mode, error pulses and kicks are ignored: no request and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_launch | input | 1 | With `wr_en`: start application mode |
| wr_data | input | 39 | Control word to write |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | 0 control word, 1 status |
| rd_valid | output | 1 | Read data valid (one cycle) |
| rd_data | output | 39 | Read data |
| err_crc | input | 1 | CRC error pulse |
| err_ext | input | 1 | External error pulse |
| err_early_done | input | 1 | Done-too-early pulse |
| err_bad_image | input | 1 | Invalid-image pulse |
| wd_kick | input | 1 | Watchdog reload pulse |
| reconfig_req | output | 1 | Fallback reconfiguration request |
| app_mode | output | 1 | 1 while the application image is selected |
| boot_addr | output | 24 | Selected boot address |

## Verification
The fallback path is driven by each error source alone and by three sources in one cycle. A lone source shows that the correct status bit is mapped. The combined case separates recording every cause from issuing more than one request. The watchdog is run with a mid-run kick, then left to expire. This pins the exact expiry edge and shows that a kick restarts the full count rather than merely postponing it. The early-done and invalid-image pulses are sent with the check option both on and off, which shows that the option bit gates them. Error pulses in factory mode, writes in application mode, and a status read that coincides with a new trigger cover the cases where something must have no effect or must survive a clear.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  // status bit indices (bit order is visible to software)
  localparam int ST_CRC   = 0;
  localparam int ST_EXT   = 1;
  localparam int ST_EARLY = 2;
  localparam int ST_BAD   = 3;
  localparam int ST_WDOG  = 4;
  localparam int STAT_W   = 5;
endpackage

// File: rtl/recfg_ctrl_reg.sv
module recfg_ctrl_reg #(
  parameter int                  CTRL_W    = 39,
  parameter logic [CTRL_W-1:0]   RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_launch,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              trig_any,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              app_mode,
  output logic              launch
);
  logic accept;
  // writes are only honoured from the factory image
  assign accept = wr_en && !app_mode;
  assign launch = accept && wr_launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= RESET_VAL;
      app_mode <= 1'b0;
    end else begin
      if (accept) ctrl_q <= wr_data;
      if (trig_any)    app_mode <= 1'b0;
      else if (launch) app_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/recfg_wdog.sv
module recfg_wdog #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             kick_ok;

  assign kick_ok = active && kick;
  assign expire  = active && !kick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (start || kick_ok)  cnt <= reload;
    else if (active && cnt != '0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/recfg_status.sv
module recfg_status #(
  parameter int STAT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr,
  output logic [STAT_W-1:0] status_q
);
  logic [STAT_W-1:0] kept;
  assign kept = clr ? '0 : status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= kept | set_vec;
  end
endmodule

// File: rtl/recfg_supervisor.sv
module recfg_supervisor
  import recfg_pkg::*;
#(
  parameter int WD_FIELD_W   = 12,
  parameter int WD_LOW_W     = 17,
  parameter int WD_LOW_PAT   = 8,
  parameter int ADDR_FIELD_W = 22,
  parameter int ADDR_SHIFT   = 2,
  localparam int CTRL_W      = WD_FIELD_W + ADDR_FIELD_W + 5,
  localparam int BOOT_W      = ADDR_FIELD_W + ADDR_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_launch,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic              rd_valid,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              err_crc,
  input  logic              err_ext,
  input  logic              err_early_done,
  input  logic              err_bad_image,
  input  logic              wd_kick,
  output logic              reconfig_req,
  output logic              app_mode,
  output logic [BOOT_W-1:0] boot_addr
);
  localparam int WD_CNT_W  = WD_FIELD_W + WD_LOW_W;
  localparam int ADDR_LSB  = WD_FIELD_W;
  localparam int ADDR_MSB  = WD_FIELD_W + ADDR_FIELD_W - 1;
  localparam int B_SPARE1  = ADDR_MSB + 1;
  localparam int B_WD_EN   = ADDR_MSB + 2;
  localparam int B_OSC     = ADDR_MSB + 3;
  localparam int B_CHECK   = ADDR_MSB + 4;
  localparam int B_SPARE2  = ADDR_MSB + 5;
  localparam logic [CTRL_W-1:0] CTRL_RST =
    (CTRL_W'(1) << B_SPARE2) | (CTRL_W'(1) << B_CHECK) |
    (CTRL_W'(1) << B_OSC)    | (CTRL_W'(1) << B_WD_EN);

  logic [CTRL_W-1:0]   ctrl_q;
  logic [STAT_W-1:0]   status_q;
  logic [STAT_W-1:0]   trig;
  logic                trig_any;
  logic                launch;
  logic                wd_expire;
  logic [CTRL_W-1:0]   wd_src;
  logic [WD_CNT_W-1:0] wd_reload;

  recfg_ctrl_reg #(.CTRL_W(CTRL_W), .RESET_VAL(CTRL_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_launch(wr_launch),
    .wr_data(wr_data), .trig_any(trig_any), .ctrl_q(ctrl_q),
    .app_mode(app_mode), .launch(launch)
  );

  // at launch the new word is not yet stored, so take the field from the bus
  assign wd_src    = launch ? wr_data : ctrl_q;
  assign wd_reload = {wd_src[WD_FIELD_W-1:0], WD_LOW_W'(WD_LOW_PAT)};

  recfg_wdog #(.CNT_W(WD_CNT_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .start(launch),
    .active(app_mode && ctrl_q[B_WD_EN]), .kick(wd_kick),
    .reload(wd_reload), .expire(wd_expire)
  );

  always_comb begin
    trig           = '0;
    trig[ST_CRC]   = app_mode && err_crc;
    trig[ST_EXT]   = app_mode && err_ext;
    trig[ST_EARLY] = app_mode && ctrl_q[B_CHECK] && err_early_done;
    trig[ST_BAD]   = app_mode && ctrl_q[B_CHECK] && err_bad_image;
    trig[ST_WDOG]  = wd_expire;
  end
  assign trig_any = |trig;

  recfg_status #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(trig),
    .clr(rd_en && rd_sel), .status_q(status_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reconfig_req <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
    end else begin
      reconfig_req <= trig_any;
      rd_valid     <= rd_en;
      if (rd_en)
        rd_data <= rd_sel ? {{(CTRL_W-STAT_W){1'b0}}, status_q} : ctrl_q;
    end
  end

  assign boot_addr = app_mode ? {ctrl_q[ADDR_MSB:ADDR_LSB], {ADDR_SHIFT{1'b0}}}
                              : '0;
endmodule

// File: rtl/recfg_supervisor_chk.sv
module recfg_supervisor_chk #(
  parameter int CTRL_W = 39,
  parameter int BOOT_W = 24,
  parameter int STAT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_sel,
  input logic              app_mode,
  input logic              reconfig_req,
  input logic [BOOT_W-1:0] boot_addr,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [STAT_W-1:0] status_q
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |=> !reconfig_req); // R9

  AST_REQ_FACTORY_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |-> (!app_mode && boot_addr == '0)); // R9

  AST_APP_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (app_mode && $past(app_mode)) |-> (ctrl_q == $past(ctrl_q))); // R5

  AST_FACTORY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(app_mode) |-> !reconfig_req); // R12

  AST_BOOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode |-> (boot_addr[1:0] == 2'b00)); // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en && rd_sel) |-> ((status_q & $past(status_q)) == $past(status_q))); // R10
endmodule

bind recfg_supervisor recfg_supervisor_chk #(
  .CTRL_W(CTRL_W), .BOOT_W(BOOT_W), .STAT_W(recfg_pkg::STAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
  .app_mode(app_mode), .reconfig_req(reconfig_req), .boot_addr(boot_addr),
  .ctrl_q(ctrl_q), .status_q(status_q)
);

// File: tb/sim_recfg_supervisor.sv
`timescale 1ns/1ps
module sim_recfg_supervisor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_launch = 0, rd_en = 0, rd_sel = 0;
  logic [38:0] wr_data = '0;
  logic        rd_valid;
  logic [38:0] rd_data;
  logic        err_crc = 0, err_ext = 0, err_early_done = 0, err_bad_image = 0;
  logic        wd_kick = 0;
  logic        reconfig_req, app_mode;
  logic [23:0] boot_addr;

  int n_chk = 0, n_fail = 0;
  logic [38:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  recfg_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_launch(wr_launch),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid),
    .rd_data(rd_data), .err_crc(err_crc), .err_ext(err_ext),
    .err_early_done(err_early_done), .err_bad_image(err_bad_image),
    .wd_kick(wd_kick), .reconfig_req(reconfig_req), .app_mode(app_mode),
    .boot_addr(boot_addr)
  );

  function automatic logic [38:0] mk(input logic chk, input logic osc,
                                     input logic wd, input logic [21:0] addr,
                                     input logic [11:0] fld);
    return {1'b1, chk, osc, wd, 1'b0, addr, fld};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [38:0] v, input logic go);
    wr_en = 1; wr_data = v; wr_launch = go; cyc(); wr_en = 0; wr_launch = 0;
  endtask

  // driver: push expected read value, then issue the read
  task automatic rd(input logic sel, input logic [38:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1; rd_sel = sel; cyc(); rd_en = 0;
  endtask

  // monitor: compare each returned read with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R3 actual=%0h expected=none", rd_data);
      end else begin
        automatic logic [38:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 64'(rd_data), 64'(e));
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [38:0] a, b, c, d;
    a = mk(1, 1, 0, 22'h12345, 12'h000);
    b = mk(1, 1, 1, 22'h2ABCD, 12'h000);
    c = mk(0, 1, 0, 22'h00010, 12'h000);
    d = mk(1, 0, 0, 22'h3F00F, 12'h000);
    @(negedge clk);
    repeat (3) cyc();
    rst_n = 1; cyc();

    check("R1 mode", 64'(app_mode), 0);
    check("R1 boot", 64'(boot_addr), 0);
    check("R9 idle req", 64'(reconfig_req), 0);
    rd(0, 39'h78_0000_0000, "R1 default");

    wr(a, 0);
    rd(0, a, "R2 store");
    check("R3 stays factory", 64'(app_mode), 0);
    check("R4 factory boot", 64'(boot_addr), 0);

    // watchdog run: launch at E0, kick at E3, expiry on E12
    wr(b, 1);
    check("R4 mode", 64'(app_mode), 1);
    check("R4 boot", 64'(boot_addr), 64'({22'h2ABCD, 2'b00}));
    wr(a, 0);
    rd(0, b, "R5 ignored");
    wd_kick = 1; cyc(); wd_kick = 0;
    repeat (8) cyc();
    check("R6 before expiry", 64'(reconfig_req), 0);
    cyc();
    check("R6 expiry", 64'(reconfig_req), 1);
    check("R9 mode drop", 64'(app_mode), 0);
    check("R9 boot zero", 64'(boot_addr), 0);
    cyc();
    check("R9 single", 64'(reconfig_req), 0);
    rd(1, 39'h10, "R10 wdog bit");
    rd(1, 39'h0, "R10 cleared");

    // factory-mode errors ignored
    err_crc = 1; err_ext = 1; err_early_done = 1; wd_kick = 1; cyc();
    err_crc = 0; err_ext = 0; err_early_done = 0; wd_kick = 0;
    check("R12 no req", 64'(reconfig_req), 0);
    rd(1, 39'h0, "R12 no status");

    // check option off: early/bad ignored, watchdog off
    wr(c, 1);
    err_early_done = 1; err_bad_image = 1; cyc();
    err_early_done = 0; err_bad_image = 0;
    check("R7 gated req", 64'(reconfig_req), 0);
    check("R7 still app", 64'(app_mode), 1);
    rd(1, 39'h0, "R7 gated status");
    repeat (12) cyc();
    check("R6 disabled", 64'(reconfig_req | !app_mode), 0);
    err_crc = 1; cyc(); err_crc = 0;
    check("R8 crc req", 64'(reconfig_req), 1);
    rd(1, 39'h1, "R8 crc bit");

    // check option on: early done triggers
    wr(d, 1);
    err_early_done = 1; cyc(); err_early_done = 0;
    check("R7 early req", 64'(reconfig_req), 1);
    rd(1, 39'h4, "R7 early bit");

    // several triggers at once
    wr(d, 1);
    err_crc = 1; err_ext = 1; err_bad_image = 1; cyc();
    err_crc = 0; err_ext = 0; err_bad_image = 0;
    check("R11 req", 64'(reconfig_req), 1);
    cyc();
    check("R11 single", 64'(reconfig_req), 0);
    rd(1, 39'h0B, "R11 all bits");

    // trigger in the same cycle as a status read survives the clear
    wr(d, 1);
    exp_q.push_back(39'h0); tag_q.push_back("R10 read before set");
    rd_en = 1; rd_sel = 1; err_ext = 1; cyc();
    rd_en = 0; err_ext = 0;
    check("R8 ext req", 64'(reconfig_req), 1);
    rd(1, 39'h2, "R10 kept bit");

    repeat (3) cyc();
    check("R3 scoreboard drained", 64'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule